// File: doc/BRIEF.md
# External Bus Address-Latch Strobe Generator

This block derives the address-latch strobe for an 8-bit microcontroller's external memory bus directly from the oscillator clock. A modulo-six window counter, cleared by reset, divides the oscillator. The strobe is high for one oscillator period at the start of each six-clock window.

A one-byte auxiliary control register sits on the special-function-register bus. It is byte-wide and has no per-bit access. One of its bits selects gated operation. In that mode a window's strobe is emitted only if the core reports an external-data move or code-memory table read at the moment that window opens. A second register bit is exported to enable the analog converter's low-voltage charge pump.

The register reads back through a registered read port. Unimplemented bits read as zero, and one fixed bit reads as one.

Top module: `ale_strobe_gen`

## Requirements
- R1: After synchronous reset the register reads 8'h06: suppress bit (bit 0) = 0, fixed bit 1 = 1, pump enable (bit 2) = 1, bits 7..3 = 0. `adc_pump_en` is 1 and `ale` is 0.
- R2: With bit 0 = 0, `ale` is high in the cycle after every edge at which the window counter is at phase 0. This gives one pulse every 6 clocks. The first pulse is in the cycle after the first edge that follows reset release.
- R3: Every `ale` pulse is exactly one clock wide.
- R4: With bit 0 = 1, `movx_movc_active` is sampled on the window's opening edge. The window's pulse is emitted only if that input is 1 at that edge, and no pulse appears at any other time.
- R5: A write to address 8'h8E sets `adc_pump_en` to write-data bit 2 from the next clock edge on.
- R6: A write to any address other than 8'h8E changes neither `adc_pump_en`, the strobe mode nor the register read value.
- R7: Write-data bits 7..3 and bit 1 are ignored. Reads always return 0 in bits 7..3 and 1 in bit 1.
- R8: `sfr_rdata` is registered. One cycle after `sfr_rd` with address 8'h8E, it shows the register value as it stood before that edge. It is 0 otherwise.
- R9: A write to bit 0 takes effect on the edge after the write edge. A window that opens on the write edge itself still follows the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_we | input | 1 | Register write strobe |
| sfr_rd | input | 1 | Register read strobe |
| sfr_addr | input | 8 | Register bus address |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Registered read data |
| movx_movc_active | input | 1 | Core is in an external-data move or code-table read cycle |
| ale | output | 1 | Address-latch strobe |
| adc_pump_en | output | 1 | Converter charge-pump enable |

## Verification
The hardest case to reach is a mode change that lands exactly on a window's opening edge. At that edge the old mode must still decide the pulse, while a change made one cycle earlier must already apply. The bench tracks the window phase arithmetically from reset. It places writes to the suppress bit at every one of the six phases, with the core-cycle input both high and low. It also sweeps all 64 six-window patterns of that input in gated mode.

// File: rtl/ale_pkg.sv
package ale_pkg;
  localparam int unsigned SFR_AW = 8;
  localparam int unsigned SFR_DW = 8;
  localparam logic [SFR_AW-1:0] AUXCTL_ADDR = 8'h8E;
  localparam int unsigned STROBE_DIV = 6;

  typedef struct packed {
    logic [4:0] rsvd;
    logic       pump_en;
    logic       fixed_one;
    logic       suppress;
  } auxctl_t;

  localparam auxctl_t AUXCTL_RESET = '{rsvd: 5'b0, pump_en: 1'b1, fixed_one: 1'b1, suppress: 1'b0};
endpackage

// File: rtl/auxctl_reg.sv
module auxctl_reg
  import ale_pkg::*;
#(
  parameter int unsigned AW = SFR_AW,
  parameter logic [AW-1:0] REG_ADDR = AUXCTL_ADDR
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          suppress,
  output logic          pump_en
);
  auxctl_t ctl_q;
  logic    hit;
  logic    unused_wbits;

  assign hit          = (addr == REG_ADDR);
  assign unused_wbits = ^{wdata[7:3], wdata[1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= AUXCTL_RESET;
    end else if (we && hit) begin
      ctl_q.suppress <= wdata[0];
      ctl_q.pump_en  <= wdata[2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd && hit) begin
      rdata <= {5'b0, ctl_q.pump_en, 1'b1, ctl_q.suppress};
    end else begin
      rdata <= '0;
    end
  end

  assign suppress = ctl_q.suppress;
  assign pump_en  = ctl_q.pump_en;

  assert_write_pump_R5: assert property (@(posedge clk) disable iff (rst)
    (we && hit) |=> (pump_en == $past(wdata[2])));

  assert_foreign_write_R6: assert property (@(posedge clk) disable iff (rst)
    (we && !hit) |=> ($stable(pump_en) && $stable(suppress)));

  assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pump_en && !suppress));
endmodule

// File: rtl/window_counter.sv
module window_counter #(
  parameter int unsigned DIV = 6,
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] phase,
  output logic          win_start
);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  generate
    if (DIV > 1) begin : g_count
      always_ff @(posedge clk) begin
        if (rst)                phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
      end
    end else begin : g_single
      always_ff @(posedge clk) phase <= '0;
    end
  endgenerate

  assign win_start = (phase == '0);

  assert_phase_range_R2: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST);
endmodule

// File: rtl/ale_gate.sv
module ale_gate (
  input  logic clk,
  input  logic rst,
  input  logic win_start,
  input  logic suppress,
  input  logic cycle_active,
  output logic ale
);
  always_ff @(posedge clk) begin
    if (rst) ale <= 1'b0;
    else     ale <= win_start && (!suppress || cycle_active);
  end

  assert_free_run_R2: assert property (@(posedge clk) disable iff (rst)
    (win_start && !suppress) |=> ale);

  assert_gated_off_R4: assert property (@(posedge clk) disable iff (rst)
    (win_start && suppress && !cycle_active) |=> !ale);

  assert_gated_on_R4: assert property (@(posedge clk) disable iff (rst)
    (win_start && suppress && cycle_active) |=> ale);
endmodule

// File: rtl/ale_strobe_gen.sv
module ale_strobe_gen
  import ale_pkg::*;
#(
  parameter int unsigned DIV = STROBE_DIV,
  parameter int unsigned AW  = SFR_AW,
  parameter logic [AW-1:0] REG_ADDR = AUXCTL_ADDR
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sfr_we,
  input  logic          sfr_rd,
  input  logic [AW-1:0] sfr_addr,
  input  logic [7:0]    sfr_wdata,
  output logic [7:0]    sfr_rdata,
  input  logic          movx_movc_active,
  output logic          ale,
  output logic          adc_pump_en
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          suppress;
  logic [PW-1:0] phase;
  logic          win_start;

  auxctl_reg #(.AW(AW), .REG_ADDR(REG_ADDR)) ctl_i (
    .clk(clk), .rst(rst), .we(sfr_we), .rd(sfr_rd), .addr(sfr_addr),
    .wdata(sfr_wdata), .rdata(sfr_rdata), .suppress(suppress),
    .pump_en(adc_pump_en)
  );

  window_counter #(.DIV(DIV)) cnt_i (
    .clk(clk), .rst(rst), .phase(phase), .win_start(win_start)
  );

  ale_gate gate_i (
    .clk(clk), .rst(rst), .win_start(win_start), .suppress(suppress),
    .cycle_active(movx_movc_active), .ale(ale)
  );

  generate
    if (DIV > 1) begin : g_width_chk
      assert_pulse_width_R3: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);
      assert_pulse_phase_R2: assert property (@(posedge clk) disable iff (rst)
        ale |-> (phase == PW'(1)));
    end
  endgenerate
endmodule

// File: tb/ale_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module ale_strobe_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sfr_we = 1'b0, sfr_rd = 1'b0;
  logic [7:0] sfr_addr = 8'h00, sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic       movx_movc_active = 1'b0;
  logic       ale, adc_pump_en;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  int         m_ph = 0;
  logic       m_ale = 0, m_ao = 0, m_pump = 1, prev_ale = 0;
  logic [7:0] m_rd = 0;
  string      ptag = "R5";

  always #2 clk = ~clk;

  ale_strobe_gen dut_i (
    .clk(clk), .rst(rst), .sfr_we(sfr_we), .sfr_rd(sfr_rd),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .movx_movc_active(movx_movc_active), .ale(ale), .adc_pump_en(adc_pump_en)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cyc(input logic r, input logic w, input logic [7:0] a,
                     input logic [7:0] d, input logic rd, input logic act);
    logic ao_used;
    rst = r; sfr_we = w; sfr_addr = a; sfr_wdata = d; sfr_rd = rd;
    movx_movc_active = act;
    ao_used = m_ao;
    if (r) begin
      m_ph = 0; m_ale = 0; m_ao = 0; m_pump = 1; m_rd = 0;
    end else begin
      m_rd  = (rd && a == 8'h8E) ? {5'b0, m_pump, 1'b1, m_ao} : 8'h00;
      m_ale = (m_ph == 0) && (!m_ao || act);
      m_ph  = (m_ph == 5) ? 0 : m_ph + 1;
      if (w && a == 8'h8E) begin m_ao = d[0]; m_pump = d[2]; end
    end
    @(negedge clk);
    chk(ao_used ? "R4" : "R2", {7'b0, ale}, {7'b0, m_ale});
    chk(ptag, {7'b0, adc_pump_en}, {7'b0, m_pump});
    chk(rd ? "R8" : "R7", sfr_rdata, m_rd);
    if (ale) chk("R3", {7'b0, prev_ale}, 8'h00);
    prev_ale = ale;
  endtask

  task automatic idle(input int n, input logic act);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 8'h00, 0, act);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cyc(0, 1, a, d, 0, 0);
  endtask

  task automatic rdreg();
    cyc(0, 0, 8'h8E, 8'h00, 1, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    ptag = "R1";
    cyc(1, 0, 8'h00, 8'h00, 0, 0);
    cyc(1, 0, 8'h00, 8'h00, 0, 0);
    rdreg();
    chk("R1", sfr_rdata, 8'h06);
    // R2 / R3: free-running strobe with core input toggling
    ptag = "R5";
    for (int i = 0; i < 60; i++) cyc(0, 0, 8'h00, 8'h00, 0, (i % 3) == 1);
    // R5 / R7: all write-data values, read back each
    for (int v = 0; v < 256; v++) begin
      wr(8'h8E, 8'(v));
      rdreg();
      idle(v % 4, 1'b0);
    end
    // R6: writes to every other address are ignored
    wr(8'h8E, 8'h04);
    ptag = "R6";
    for (int a = 0; a < 256; a++) begin
      if (a != 'h8E) begin
        wr(8'(a), 8'hFF);
        cyc(0, 0, 8'(a), 8'h00, 1, 0);
      end
    end
    rdreg();
    chk("R6", sfr_rdata, 8'h06);
    // R4: gated mode, all six-window input patterns
    ptag = "R5";
    wr(8'h8E, 8'h01);
    for (int p = 0; p < 64; p++)
      for (int k = 0; k < 6; k++)
        for (int j = 0; j < 6; j++)
          cyc(0, 0, 8'h00, 8'h00, 0, p[k] ? (j != 3) : (j == 3));
    // R9: mode writes at every phase, core input high and low
    ptag = "R9";
    for (int ph = 0; ph < 6; ph++)
      for (int act = 0; act < 2; act++) begin
        idle(ph, act[0]);
        wr(8'h8E, 8'h00);
        idle(7, act[0]);
        wr(8'h8E, 8'h01);
        idle(13, act[0]);
      end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule